// File: doc/BRIEF.md
# Wavefront CTU Row Scheduler

This block hands rows of coding tree units (CTUs) to a fixed pool of parallel entropy-coding workers so that a picture is coded as a diagonal wavefront. Row `r` always goes to worker `r mod NUM_LANES`. Each worker codes its row left to right, one CTU at a time. A worker starts a CTU only when enough of the row above has been completed, so that the left, upper-left, upper and upper-right neighbours are already available. The block therefore keeps a two-CTU lag between adjacent rows. The scheduler does not hold or move any context-model data. It only tells an external snapshot store when to capture a worker's state and when to restore it.

The entropy-coder state is re-initialised at the start of every row. Every row except the first starts from a snapshot of the row above. That snapshot is taken once the second CTU of the row above has finished, or its only CTU if the picture is one CTU wide. The first row starts from default contexts and loads nothing. A picture is launched with a single `pic_go` pulse carrying the width and height in CTUs. The scheduler drives per-worker start pulses with row and column indices. It counts the per-worker completion pulses, and it pulses `pic_done` when the final CTU has completed. It then returns to idle.

Scheduler states:
- `S_IDLE`: waits for a launch.
- `S_RUN`: a picture is in progress.
- `S_DONE`: `pic_done` is high for one cycle.

Scheduler transitions:
- `S_IDLE` to `S_RUN` on a `pic_go` with non-zero dimensions.
- `S_RUN` to `S_DONE` once every worker lane is idle.
- `S_DONE` to `S_IDLE` unconditionally.

Lane states:
- `L_IDLE`: the lane holds no row.
- `L_WAIT`: the lane waits until the dependency for its next column is met.
- `L_BUSY`: one CTU is in flight on the lane.

Lane transitions:
- `L_IDLE` to `L_WAIT` on launch, if the lane has a row in the picture.
- `L_WAIT` to `L_BUSY` when the dependency is met. The start pulse is issued on this transition.
- `L_BUSY` to `L_WAIT` on a completion pulse when another column remains, or when the lane has a further row `r+NUM_LANES`.
- `L_BUSY` to `L_IDLE` on the completion pulse of its last column when no further row exists.

Top module: `wavefront_sched`

## Requirements
- R1: After reset `ctu_go`, `snap_save`, `snap_load`, `pic_done` and `busy` are all 0.
- R2: Every start pulse on worker `w` carries a row index `r` with `r mod 4 == w` (4 workers by default).
- R3: A start of column 0 of row `r > 0` is accompanied, in the same cycle, by `snap_load = 1` with `snap_load_row = r`. A start of column 0 of row 0 is not accompanied by a load.
- R4: For every row `r < H-1`, exactly one `snap_save` pulse with `snap_save_row = r` occurs. It appears in the cycle after the completion pulse that brings row `r` to `min(2, W)` completed CTUs. No save is made for the last row.
- R5: Column `c` of row `r > 0` is started only after row `r-1` has completed at least `min(c+2, W)` CTUs, counting completion pulses sampled at least one clock edge before the start decision.
- R6: Within a row, columns start in order 0 to `W-1`. A worker receives a new start only after the completion pulse of its previous CTU.
- R7: A worker starts row `r+4` only after all `W` CTUs of its row `r` have completed.
- R8: `pic_done` is high for exactly one cycle, two cycles after the cycle in which the last completion pulse of the picture is driven. In the following cycle `busy` is 0.
- R9: `pic_go` is ignored while a picture is in progress, and also when the width or the height is 0. Either case leaves the running picture and its dimensions unchanged, or starts nothing.
- R10: A snapshot load for row `r` never occurs before the snapshot save for row `r-1`.
- R11: Each CTU of the `W x H` picture is started exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pic_go | input | 1 | Launch pulse for a new picture, accepted only when idle |
| pic_cols | input | COL_W | Picture width in CTUs, sampled with `pic_go` |
| pic_rows | input | ROW_W | Picture height in CTU rows, sampled with `pic_go` |
| ctu_done | input | NUM_LANES | Per-worker completion pulse for the CTU in flight |
| ctu_go | output | NUM_LANES | Per-worker start pulse |
| ctu_row | output | NUM_LANES*ROW_W | Per-worker row index, worker `w` in bits `[w*ROW_W +: ROW_W]`, valid with `ctu_go` |
| ctu_col | output | NUM_LANES*COL_W | Per-worker column index, worker `w` in bits `[w*COL_W +: COL_W]`, valid with `ctu_go` |
| snap_save | output | 1 | Capture-snapshot strobe |
| snap_save_row | output | ROW_W | Row whose state is captured |
| snap_load | output | 1 | Restore-snapshot strobe |
| snap_load_row | output | ROW_W | Row that receives the snapshot of the row above |
| pic_done | output | 1 | One-cycle picture-complete pulse |
| busy | output | 1 | A picture is in progress |

## Verification
The bound checker watches several behaviours on every cycle:
- the mapping from row to worker;
- that every column-0 start of a non-first row carries its load strobe;
- that a worker never gets a second start while a CTU is in flight;
- that loads never outnumber earlier saves;
- that every save follows a completion pulse;
- the single-cycle `pic_done` pulse and the return to idle.

The wavefront lag itself can only be shown by the bench's scenarios. So can the exact completion count at which each snapshot is taken, the one-start-per-CTU coverage of the whole picture, and the rejection of a mid-picture or zero-sized launch. For these the bench keeps its own per-row completion counts and replays random worker latencies, narrow and single-row pictures, and a stray launch during a running picture.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_DONE
    } sched_state_t;

    typedef enum logic [1:0] {
        L_IDLE,
        L_WAIT,
        L_BUSY
    } lane_state_t;

endpackage

// File: rtl/wf_snap_pick.sv
module wf_snap_pick #(
    parameter int N     = 4,
    parameter int ROW_W = 8
) (
    input  logic [N-1:0]       req,
    input  logic [N*ROW_W-1:0] rows,
    output logic               vld,
    output logic [ROW_W-1:0]   row
);

    // Lowest-numbered requester wins; the wavefront lag keeps requests apart.
    always_comb begin
        vld = |req;
        row = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                row = rows[i*ROW_W +: ROW_W];
            end
        end
    end

endmodule

// File: rtl/wf_lane.sv
module wf_lane
    import wf_pkg::*;
#(
    parameter int LANE      = 0,
    parameter int NUM_LANES = 4,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [COL_W-1:0] cols,
    input  logic [ROW_W-1:0] rows,
    input  logic [ROW_W:0]   up_row,
    input  logic [COL_W-1:0] up_cnt,
    input  logic             ctu_done,
    output logic [ROW_W:0]   my_row,
    output logic [COL_W-1:0] my_cnt,
    output logic             go,
    output logic             load_req,
    output logic             save_req,
    output logic [ROW_W-1:0] save_row,
    output logic             active
);

    localparam int RW1 = ROW_W + 1;
    localparam int CW1 = COL_W + 1;

    lane_state_t      st_q, st_n;
    logic [RW1-1:0]   row_q;
    logic [COL_W-1:0] cnt_q;
    logic [CW1-1:0]   need, cnt_inc, save_pt, two_ahead;
    logic             dep_ok, last_col, more_rows, has_below, hit_save;

    // Dependency and bookkeeping terms derived from the current position
    always_comb begin
        two_ahead = {1'b0, cnt_q} + CW1'(2);
        need      = (two_ahead < {1'b0, cols}) ? two_ahead : {1'b0, cols};
        dep_ok    = (row_q == '0) || (up_row > (row_q - RW1'(1))) ||
                    ({1'b0, up_cnt} >= need);
        cnt_inc   = {1'b0, cnt_q} + CW1'(1);
        last_col  = (cnt_inc == {1'b0, cols});
        save_pt   = (cols == COL_W'(1)) ? CW1'(1) : CW1'(2);
        more_rows = (row_q + RW1'(NUM_LANES)) < {1'b0, rows};
        has_below = (row_q + RW1'(1)) < {1'b0, rows};
        hit_save  = (cnt_inc == save_pt) && has_below;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            L_IDLE: if (launch && (RW1'(LANE) < {1'b0, rows})) st_n = L_WAIT;
            L_WAIT: if (dep_ok) st_n = L_BUSY;
            L_BUSY: begin
                if (ctu_done) begin
                    st_n = (!last_col || more_rows) ? L_WAIT : L_IDLE;
                end
            end
            default: st_n = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= L_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q    <= '0;
            cnt_q    <= '0;
            go       <= 1'b0;
            load_req <= 1'b0;
            save_req <= 1'b0;
            save_row <= '0;
        end else begin
            go       <= (st_q == L_WAIT) && dep_ok;
            load_req <= (st_q == L_WAIT) && dep_ok && (cnt_q == '0) && (row_q != '0);
            save_req <= (st_q == L_BUSY) && ctu_done && hit_save;
            if ((st_q == L_BUSY) && ctu_done && hit_save) begin
                save_row <= row_q[ROW_W-1:0];
            end
            if ((st_q == L_IDLE) && launch) begin
                row_q <= RW1'(LANE);
                cnt_q <= '0;
            end else if ((st_q == L_BUSY) && ctu_done) begin
                if (last_col && more_rows) begin
                    row_q <= row_q + RW1'(NUM_LANES);
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_inc[COL_W-1:0];
                end
            end
        end
    end

    assign my_row = row_q;
    assign my_cnt = cnt_q;
    assign active = (st_q != L_IDLE);

endmodule

// File: rtl/wavefront_sched.sv
module wavefront_sched
    import wf_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pic_go,
    input  logic [COL_W-1:0]           pic_cols,
    input  logic [ROW_W-1:0]           pic_rows,
    input  logic [NUM_LANES-1:0]       ctu_done,
    output logic [NUM_LANES-1:0]       ctu_go,
    output logic [NUM_LANES*ROW_W-1:0] ctu_row,
    output logic [NUM_LANES*COL_W-1:0] ctu_col,
    output logic                       snap_save,
    output logic [ROW_W-1:0]           snap_save_row,
    output logic                       snap_load,
    output logic [ROW_W-1:0]           snap_load_row,
    output logic                       pic_done,
    output logic                       busy
);

    sched_state_t state_q, state_n;
    logic [COL_W-1:0] cols_q, cols_use;
    logic [ROW_W-1:0] rows_q, rows_use;
    logic             launch;

    logic [ROW_W:0]   lrow [NUM_LANES];
    logic [COL_W-1:0] lcnt [NUM_LANES];
    logic [NUM_LANES-1:0]       lsave, lload, lactive;
    logic [NUM_LANES*ROW_W-1:0] save_rows, load_rows;

    // Picture-level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_n = S_RUN;
            S_RUN:  if (lactive == '0) state_n = S_DONE;
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // Picture-level outputs
    always_comb begin
        launch   = (state_q == S_IDLE) && pic_go &&
                   (pic_cols != '0) && (pic_rows != '0);
        busy     = (state_q != S_IDLE);
        pic_done = (state_q == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cols_q <= '0;
            rows_q <= '0;
        end else if (launch) begin
            cols_q <= pic_cols;
            rows_q <= pic_rows;
        end
    end

    assign cols_use = launch ? pic_cols : cols_q;
    assign rows_use = launch ? pic_rows : rows_q;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int UP = (g + NUM_LANES - 1) % NUM_LANES;
        logic [ROW_W-1:0] srow;

        wf_lane #(
            .LANE(g), .NUM_LANES(NUM_LANES), .COL_W(COL_W), .ROW_W(ROW_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .launch   (launch),
            .cols     (cols_use),
            .rows     (rows_use),
            .up_row   (lrow[UP]),
            .up_cnt   (lcnt[UP]),
            .ctu_done (ctu_done[g]),
            .my_row   (lrow[g]),
            .my_cnt   (lcnt[g]),
            .go       (ctu_go[g]),
            .load_req (lload[g]),
            .save_req (lsave[g]),
            .save_row (srow),
            .active   (lactive[g])
        );

        assign ctu_row[g*ROW_W +: ROW_W]   = lrow[g][ROW_W-1:0];
        assign ctu_col[g*COL_W +: COL_W]   = lcnt[g];
        assign save_rows[g*ROW_W +: ROW_W] = srow;
        assign load_rows[g*ROW_W +: ROW_W] = lrow[g][ROW_W-1:0];
    end

    wf_snap_pick #(.N(NUM_LANES), .ROW_W(ROW_W)) i_save_pick (
        .req  (lsave),
        .rows (save_rows),
        .vld  (snap_save),
        .row  (snap_save_row)
    );

    wf_snap_pick #(.N(NUM_LANES), .ROW_W(ROW_W)) i_load_pick (
        .req  (lload),
        .rows (load_rows),
        .vld  (snap_load),
        .row  (snap_load_row)
    );

endmodule

// File: rtl/wf_sched_chk.sv
module wf_sched_chk #(
    parameter int NUM_LANES = 4,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_LANES-1:0]       ctu_go,
    input logic [NUM_LANES*ROW_W-1:0] ctu_row,
    input logic [NUM_LANES*COL_W-1:0] ctu_col,
    input logic [NUM_LANES-1:0]       ctu_done,
    input logic                       snap_save,
    input logic                       snap_load,
    input logic [ROW_W-1:0]           snap_load_row,
    input logic                       pic_done,
    input logic                       busy
);

    logic [15:0]          save_cnt, load_cnt;
    logic [NUM_LANES-1:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_cnt <= '0;
            load_cnt <= '0;
            inflight <= '0;
        end else begin
            inflight <= (inflight | ctu_go) & ~ctu_done;
            if (!busy) begin
                save_cnt <= '0;
                load_cnt <= '0;
            end else begin
                save_cnt <= save_cnt + 16'(snap_save);
                load_cnt <= load_cnt + 16'(snap_load);
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        // R2
        lane_row_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctu_go[g] |-> ((int'(ctu_row[g*ROW_W +: ROW_W]) % NUM_LANES) == g));

        // R3
        row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctu_go[g] && (ctu_col[g*COL_W +: COL_W] == '0) &&
             (ctu_row[g*ROW_W +: ROW_W] != '0))
            |-> (snap_load && (snap_load_row == ctu_row[g*ROW_W +: ROW_W])));

        // R6
        one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctu_go[g] |-> !inflight[g]);
    end

    // R10
    load_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_load |-> (save_cnt > load_cnt));

    // R4
    save_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_save |-> $past(|ctu_done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pic_done |=> (!pic_done && !busy));

endmodule

bind wavefront_sched wf_sched_chk #(
    .NUM_LANES(NUM_LANES), .COL_W(COL_W), .ROW_W(ROW_W)
) i_wf_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctu_go        (ctu_go),
    .ctu_row       (ctu_row),
    .ctu_col       (ctu_col),
    .ctu_done      (ctu_done),
    .snap_save     (snap_save),
    .snap_load     (snap_load),
    .snap_load_row (snap_load_row),
    .pic_done      (pic_done),
    .busy          (busy)
);

// File: tb/test_wavefront_sched.sv
module test_wavefront_sched;

    localparam int NL    = 4;
    localparam int COL_W = 8;
    localparam int ROW_W = 8;
    localparam int MAXR  = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   pic_go = 1'b0;
    logic [COL_W-1:0]       pic_cols = '0;
    logic [ROW_W-1:0]       pic_rows = '0;
    logic [NL-1:0]          ctu_done = '0;
    logic [NL-1:0]          ctu_go;
    logic [NL*ROW_W-1:0]    ctu_row;
    logic [NL*COL_W-1:0]    ctu_col;
    logic                   snap_save, snap_load, pic_done, busy;
    logic [ROW_W-1:0]       snap_save_row, snap_load_row;

    wavefront_sched #(.NUM_LANES(NL), .COL_W(COL_W), .ROW_W(ROW_W)) i_wavefront_sched (
        .clk(clk), .rst_n(rst_n), .pic_go(pic_go), .pic_cols(pic_cols),
        .pic_rows(pic_rows), .ctu_done(ctu_done), .ctu_go(ctu_go),
        .ctu_row(ctu_row), .ctu_col(ctu_col), .snap_save(snap_save),
        .snap_save_row(snap_save_row), .snap_load(snap_load),
        .snap_load_row(snap_load_row), .pic_done(pic_done), .busy(busy)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int W, H, cyc, starts, dones, saves, loads, pd_seen, last_done;
    int cnt_now [MAXR];
    int cnt_prev[MAXR];
    int next_col[MAXR];
    bit saved   [MAXR];
    bit wbusy   [NL];
    int tmr     [NL];
    int wrow    [NL];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int min2w(input int w);
        return (w < 2) ? w : 2;
    endfunction

    function automatic int need_of(input int c, input int w);
        return (c + 2 < w) ? c + 2 : w;
    endfunction

    // One clock step: observe outputs at the falling edge, then drive the workers.
    task automatic step();
        @(negedge clk);
        cyc++;
        if (snap_save) begin
            int sr;
            sr = int'(snap_save_row) % MAXR;
            chk(int'(snap_save_row) < H - 1, "R4 save row below last", int'(snap_save_row), H - 2);
            chk(!saved[sr], "R4 single save per row", int'(saved[sr]), 0);
            chk(cnt_now[sr] == min2w(W), "R4 save after second CTU", cnt_now[sr], min2w(W));
            saved[sr] = 1'b1;
            saves++;
        end
        if (snap_load) loads++;
        for (int l = 0; l < NL; l++) begin
            if (ctu_go[l]) begin
                int r, c, ri;
                r  = int'(ctu_row[l*ROW_W +: ROW_W]);
                c  = int'(ctu_col[l*COL_W +: COL_W]);
                ri = r % MAXR;
                chk(r % NL == l, "R2 row to worker", r % NL, l);
                chk(r < H && c == next_col[ri], "R6 column order", c, next_col[ri]);
                chk(!wbusy[l], "R6 worker idle at start", int'(wbusy[l]), 0);
                if (r >= NL) chk(cnt_now[ri-NL] == W, "R7 previous row finished", cnt_now[ri-NL], W);
                if (r > 0) chk(cnt_prev[ri-1] >= need_of(c, W), "R5 wavefront lag", cnt_prev[ri-1], need_of(c, W));
                if (c == 0 && r > 0) begin
                    chk(snap_load && int'(snap_load_row) == r, "R3 load with row start", int'(snap_load_row), r);
                    chk(saved[ri-1], "R10 load after save", int'(saved[ri-1]), 1);
                end
                if (c == 0 && r == 0) chk(!snap_load, "R3 first row no load", int'(snap_load), 0);
                wbusy[l] = 1'b1;
                tmr[l]   = int'($urandom % 5);
                wrow[l]  = ri;
                next_col[ri]++;
                starts++;
            end
        end
        if (pic_done) begin
            pd_seen++;
            chk(dones == W * H, "R8 done after all CTUs", dones, W * H);
            chk(cyc - last_done == 2, "R8 done latency", cyc - last_done, 2);
            chk(starts == W * H, "R11 every CTU started once", starts, W * H);
        end
        for (int i = 0; i < MAXR; i++) cnt_prev[i] = cnt_now[i];
        ctu_done = '0;
        for (int l = 0; l < NL; l++) begin
            if (wbusy[l]) begin
                if (tmr[l] == 0) begin
                    ctu_done[l] = 1'b1;
                    wbusy[l]    = 1'b0;
                    cnt_now[wrow[l]]++;
                    dones++;
                    last_done = cyc;
                end else begin
                    tmr[l]--;
                end
            end
        end
    endtask

    task automatic run_pic(input int w, input int h, input bit inject);
        int n;
        W = w; H = h;
        starts = 0; dones = 0; saves = 0; loads = 0; pd_seen = 0; last_done = 0;
        for (int i = 0; i < MAXR; i++) begin
            cnt_now[i] = 0; cnt_prev[i] = 0; next_col[i] = 0; saved[i] = 1'b0;
        end
        for (int l = 0; l < NL; l++) wbusy[l] = 1'b0;
        pic_go   = 1'b1;
        pic_cols = COL_W'(w);
        pic_rows = ROW_W'(h);
        n = 0;
        while (pd_seen == 0 && n < 5000) begin
            step();
            pic_go = 1'b0;
            if (inject && n == 3) begin
                pic_go   = 1'b1;
                pic_cols = COL_W'(7);
                pic_rows = ROW_W'(9);
            end
            n++;
        end
        pic_go = 1'b0;
        if (pd_seen == 0) chk(1'b0, "R8 watchdog picture hung", n, 5000);
        step();
        chk(busy == 1'b0, "R8 idle after done", int'(busy), 0);
        chk(pd_seen == 1, "R8 single done pulse", pd_seen, 1);
        chk(saves == h - 1, "R4 save count", saves, h - 1);
        chk(loads == h - 1, "R3 load count", loads, h - 1);
        if (inject) chk(starts == w * h, "R9 mid-picture go ignored", starts, w * h);
    endtask

    task automatic zero_go(input int w, input int h);
        int seen;
        seen = 0;
        pic_go = 1'b1; pic_cols = COL_W'(w); pic_rows = ROW_W'(h);
        step();
        pic_go = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            if (busy || ctu_go != '0) seen++;
        end
        chk(seen == 0, "R9 zero-sized go ignored", seen, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctu_go == '0, "R1 reset starts", int'(ctu_go), 0);
        chk(!snap_save && !snap_load, "R1 reset strobes", int'({snap_save, snap_load}), 0);
        chk(!pic_done && !busy, "R1 reset done/busy", int'({pic_done, busy}), 0);

        run_pic(1, 1, 1'b0);
        run_pic(1, 6, 1'b0);
        run_pic(5, 1, 1'b0);
        run_pic(2, 3, 1'b0);
        run_pic(3, 4, 1'b0);
        run_pic(6, 5, 1'b1);
        zero_go(0, 5);
        zero_go(5, 0);
        for (int k = 0; k < 8; k++) begin
            run_pic(1 + int'($urandom % 12), 1 + int'($urandom % 12), 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule